// File: doc/BRIEF.md
# Serial Shared-Table Word Substitution

This block replaces every byte of a 32-bit word with its image under the forward AES substitution table. It does this one byte per clock and uses a single combinational table. A one-hot sequencer visits the four byte positions in turn. It steers the byte it owns onto the table's one address input through an OR-multiplexer and writes the table output back into the same byte position. The hardware therefore holds one copy of the table instead of four.

A caller pulses `start` with a word on `word_in` while the block is idle. After four substitution cycles the sequencer enters a terminal state, in which a round-constant step would follow, and raises `done` for one cycle. The substituted word stays on `word_out` until the next accepted start. Any `start` that arrives while a word is being processed, including the `done` cycle, is dropped.

Top module: `sbox_word_serial`

## Requirements
- R1: Each byte of the result is the forward AES S-box image of the input byte in the same position. For example, 0x00 becomes 0x63 and 0x53 becomes 0xED. Byte k occupies bits [8k+7:8k].
- R2: Bytes are substituted in ascending order, one per clock, starting with bits [7:0]. One clock after the load, only the low byte of `word_out` has changed.
- R3: `done` is high in the cycle that follows the fourth substitution edge. That is the clock period after the fifth rising edge, counting the edge that sampled `start` as the first.
- R4: `done` lasts exactly one cycle. The sequencer is back in idle in the next cycle and accepts a new `start` there. Exactly one sequencer state is active at any time.
- R5: Once `done` has been seen, `word_out` keeps its value until another start is accepted.
- R6: A `start` raised during any of the four substitution cycles or the `done` cycle is ignored. It neither reloads the word nor produces an extra `done`.
- R7: A synchronous active-high `rst` returns the sequencer to idle, holds `done` low and clears `word_out` to zero, even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a word; sampled only while idle |
| word_in | input | 32 | Word to substitute, loaded on an accepted start |
| word_out | output | 32 | Working word; the full result once done has pulsed |
| done | output | 1 | One-cycle pulse when all four bytes are replaced |

## Verification
The hardest conditions to create from the ports are a start that collides with a busy sequencer and a reset that cuts a word short. Both depend on a pulse landing in the right cycle relative to an earlier start. The driver raises a second start with a different word in the middle of a substitution, and again in the `done` cycle. The monitor must then see no extra `done`, and the result must still match the first word. A separate run pulls reset two cycles into a word and expects a zero result and silence on `done`. Sweeping 64 words whose bytes cover all 256 values checks every table entry.

// File: rtl/sbox_word_serial.sv
module sbox_word_serial #(
  parameter int NBYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [NBYTES*8-1:0]   word_in,
  output logic [NBYTES*8-1:0]   word_out,
  output logic                  done
);
  localparam int BW    = 8;
  localparam int WW    = NBYTES * BW;
  localparam int NST   = NBYTES + 2;
  localparam int IDLE  = 0;
  localparam int RCON  = NBYTES + 1;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox_f(input logic [7:0] b);
    logic [7:0] r, base, e;
    r    = 8'h01;
    base = b;
    e    = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = gmul(r, base);
      base = gmul(base, base);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  logic [NST-1:0] st, st_n;
  logic [WW-1:0]  word;
  logic [BW-1:0]  tbl_addr, tbl_data;

  always_comb begin
    st_n = '0;
    if (st[IDLE]) st_n[start ? 1 : IDLE] = 1'b1;
    for (int k = 1; k <= NBYTES; k++)
      if (st[k]) st_n[k+1] = 1'b1;
    if (st[RCON]) st_n[IDLE] = 1'b1;
  end

  always_comb begin
    tbl_addr = '0;
    for (int k = 0; k < NBYTES; k++)
      if (st[k+1]) tbl_addr = tbl_addr | word[k*BW +: BW];
  end

  assign tbl_data = sbox_f(tbl_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= NST'(1) << IDLE;
      word <= '0;
    end else begin
      st <= st_n;
      if (st[IDLE] && start) word <= word_in;
      for (int k = 0; k < NBYTES; k++)
        if (st[k+1]) word[k*BW +: BW] <= tbl_data;
    end
  end

  assign word_out = word;
  assign done     = st[RCON];

  a_r4_onehot_state: assert property (@(posedge clk) disable iff (rst)
    $countones(st) == 1);
  a_r3_last_byte_to_done: assert property (@(posedge clk) disable iff (rst)
    st[NBYTES] |=> done);
  a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (st[IDLE] && !start) |=> $stable(word_out));
  a_r6_busy_start_dropped: assert property (@(posedge clk) disable iff (rst)
    (!st[IDLE] && start) |=> !st[1]);
  a_r2_low_byte_first: assert property (@(posedge clk) disable iff (rst)
    st[1] |=> $stable(word_out[WW-1:BW]));
endmodule

// File: tb/sbox_word_serial_tb.sv
module sbox_word_serial_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, start = 0;
  logic [31:0] din = '0;
  logic [31:0] result;
  logic        done;
  int errs = 0, checks = 0, cyc = 0;
  bit finished = 0;
  logic [31:0] q_w[$];
  int          q_c[$];

  sbox_word_serial u_dut (.clk(clk), .rst(rst), .start(start), .word_in(din),
                          .word_out(result), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++) if (b[i]) acc = acc ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (acc[i]) acc = acc ^ (16'h011b << (i - 8));
    return acc[7:0];
  endfunction

  function automatic logic [7:0] sref(input logic [7:0] b);
    logic [7:0] inv = '0, s;
    if (b != 0) for (int y = 1; y < 256; y++) if (fmul(b, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
    return s;
  endfunction

  function automatic logic [31:0] wref(input logic [31:0] w);
    return {sref(w[31:24]), sref(w[23:16]), sref(w[15:8]), sref(w[7:0])};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops scoreboard on every done (R1, R3, R6)
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_w.size() == 0) check(0, "R6 unexpected done", result, '0);
      else begin
        logic [31:0] ew; int ec;
        ew = q_w.pop_front(); ec = q_c.pop_front();
        check(result == ew, "R1 substituted word", result, ew);
        check(cyc == ec, "R3 done cycle", 32'(cyc), 32'(ec));
      end
    end
  end

  // drives a word; probe low byte after one substitution; optional busy intrusions
  task automatic run(input logic [31:0] w, input bit probe, input bit intrude);
    @(negedge clk);
    start = 1; din = w;
    q_w.push_back(wref(w)); q_c.push_back(cyc + 5);
    @(negedge clk); start = 0;
    @(negedge clk);
    if (probe) check(result == {w[31:8], sref(w[7:0])}, "R2 low byte first", result, {w[31:8], sref(w[7:0])});
    if (intrude) begin start = 1; din = ~w; end
    @(negedge clk); start = 0;
    @(negedge clk);
    @(negedge clk);
    if (intrude) begin start = 1; din = w ^ 32'h5a5a5a5a; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(result == 0 && done == 0, "R7 reset state", {result[31:1], done}, '0);
    check(sref(8'h00) == 8'h63, "R1 model 00", 32'(sref(8'h00)), 32'h63);
    check(sref(8'h53) == 8'hed, "R1 model 53", 32'(sref(8'h53)), 32'hed);

    // full table sweep, back-to-back starts (R1, R4)
    for (int i = 0; i < 64; i++)
      run({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, i < 4, 0);
    @(negedge clk);

    // R6: starts during substitution and during done are dropped
    run(32'hdeadbeef, 1, 1);
    @(negedge clk); start = 0;
    repeat (4) @(negedge clk);
    check(result == wref(32'hdeadbeef), "R6 busy start ignored", result, wref(32'hdeadbeef));
    check(q_w.size() == 0, "R6 no extra done", 32'(q_w.size()), 0);

    // R5: hold after done
    repeat (6) @(negedge clk);
    check(result == wref(32'hdeadbeef), "R5 result held", result, wref(32'hdeadbeef));

    // R4: new start right after done cycle is accepted
    run(32'h00530053, 1, 0);
    run(32'hffffffff, 0, 0);
    @(negedge clk);
    check(q_w.size() == 0, "R4 back-to-back accepted", 32'(q_w.size()), 0);

    // R7: reset mid-word
    @(negedge clk); start = 1; din = 32'h12345678;
    @(negedge clk); start = 0;
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(result == 0 && done == 0, "R7 reset mid-word", result, '0);
    repeat (6) @(negedge clk);
    check(result == 0, "R7 stays idle after reset", result, '0);

    run(32'h01020304, 1, 0);
    repeat (3) @(negedge clk);
    check(q_w.size() == 0, "R4 scoreboard drained", 32'(q_w.size()), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule